// File: doc/BRIEF.md
# Parallel Flash Command Controller

This block models a NOR-style parallel flash device that obeys a classic multi-cycle command protocol. It holds a small byte-addressed array built from a parameterised number of uniform sectors. The array is reached through a request channel and a response channel that are one, two or four bytes wide. Each write is either a command byte, in its low eight bits, or the data that a command sequence asked for. What a read returns depends on the last command: array data, the status byte, the identifier codes or a query table. Single-word program, sector erase with confirm, buffered block write, lock/unlock confirm, status read and clear, identifier read and query mode are all decoded. A write-protect input makes program and erase attempts fail and set error bits.

Requests use a valid/ready handshake. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` goes low only while a confirmed sector erase is filling the sector. During that time the requester must hold its request, and nothing is lost. Each accepted read produces exactly one response, in the following cycle. The response channel cannot be stalled.

All addresses are byte addresses. An access of several bytes starts at any byte offset and wraps around the end of the array. With the default parameters the array is 64 bytes: 4 sectors of 16 bytes, a 16-bit bus, a buffer limit of 4 words, little-endian byte order, a manufacturer code of 0x0089 and a device code of 0x0018.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `seq_error` are 0, `req_ready` is 1, the block is in array mode, and every array byte reads 0xFF.
- R2: In array mode, a read at byte address A returns the bytes at A, A+1 and so on, modulo the array size. With BIG_ENDIAN=0, the byte at A sits in bits 7:0; with BIG_ENDIAN=1 it sits in the top byte. `rsp_valid` and `rsp_data` appear in the cycle after the read is accepted, for one cycle.
- R3: In the idle state, the low byte of a write is decoded as a command: 0x10/0x40 program, 0x20 erase, 0x50 clear status, 0x60 lock, 0x70 read status, 0x90 identifier, 0x98 query, 0xE8 buffered write, 0xFF array mode.
- R4: After 0x10 or 0x40, the next write stores its full word at its byte address. Reads then return status until another command is given.
- R5: After 0x20, a write of 0xD0 fills with 0xFF the whole sector that holds the confirm write's address, with the address aligned down to a sector boundary. `req_ready` is low for SECTOR_BYTES/BYTES cycles, and reads afterwards return status. A write of 0xFF instead cancels the erase, returns to array mode and changes no memory.
- R6: With `wr_protect` high, program and buffered data writes leave memory unchanged and set status bit 4. An erase confirm leaves memory unchanged, causes no stall and sets status bit 5.
- R7: The status byte is bit 7 ready, bit 5 erase error, bit 4 program error, and all other bits 0. It is returned zero-extended. Reads return it after commands 0x10, 0x40, 0x20, 0x50, 0x60, 0x70 and 0xE8, and after a completed erase or buffered write.
- R8: The error bits stay set across other commands until a 0x50 command clears them.
- R9: After 0xE8, the next write gives a count N. If N < BUF_WORDS, the next N+1 writes store data, and a 0xD0 write then finishes the sequence in status mode. If N >= BUF_WORDS, bit 4 is set and the block goes back to idle in status mode.
- R10: After 0x60, a write of 0xD0 or 0x01 returns to array mode with no error pulse. Any other value is an unknown sequence.
- R11: After 0x90, a read at address 0 returns MFR_CODE, at address 1 returns DEV_CODE, and at any other address returns 0.
- R12: After 0x98, a read returns the query table byte at address bits 7:0, zero-extended. The table holds 0x10='Q', 0x11='R', 0x12='Y', 0x27=log2(array bytes), 0x2A=log2(buffer bytes) and 0x2D/0x2E=sectors-1; index 0x31 and above returns 0. In identifier and query modes, every write is decoded as a new command.
- R13: An unrecognised command, or a wrong value at the erase, lock or buffer confirm step, returns the block to array mode without changing memory. `seq_error` is high for exactly the cycle after that write is accepted.
- R14: `req_ready` is low only during an erase fill. `rsp_valid` is never high except in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_protect | input | 1 | Makes program and erase attempts fail and set error bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 8*BYTES (16) | Write data or command byte in bits 7:0 |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8*BYTES (16) | Read response data |
| seq_error | output | 1 | One-cycle pulse for an unknown command sequence |

## Verification
The hardest situations to reach are the confirm steps of the multi-write sequences: a buffered write whose count is exceeded or whose confirm byte is wrong, and an erase or program attempted under write protect followed by later commands that must leave the error bits alone. Directed sequences walk each of these chains write by write. A reference byte array in the bench tracks every store and erase, so that memory left unchanged by a failed sequence is checked at the exact addresses involved. Unaligned and wrapping accesses are covered by programs at the last byte of the array and by seeded random program/read-back rounds.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE_CFM, ST_ERASING,
    ST_LOCK_CFM, ST_BUF_CNT, ST_BUF_DATA, ST_BUF_CFM
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY
  } read_mode_t;

  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLR      = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFWR    = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_SET = 8'h01;

  // Query table contents; every index not listed (including 0x31 and up) reads 0.
  function automatic logic [7:0] qry_byte(input logic [7:0] idx,
                                          input int size_log2,
                                          input int buf_log2,
                                          input int sectors,
                                          input int sector_bytes);
    logic [31:0] sc;
    logic [31:0] sb;
    logic [31:0] sl;
    logic [31:0] bl;
    sc = 32'(sectors - 1);
    sb = 32'(sector_bytes);
    sl = 32'(size_log2);
    bl = 32'(buf_log2);
    case (idx)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h1B: return 8'h45;
      8'h1C: return 8'h55;
      8'h1F: return 8'h07;
      8'h20: return 8'h07;
      8'h21: return 8'h0A;
      8'h23: return 8'h04;
      8'h24: return 8'h04;
      8'h25: return 8'h04;
      8'h27: return sl[7:0];
      8'h28: return 8'h02;
      8'h2A: return bl[7:0];
      8'h2C: return 8'h01;
      8'h2D: return sc[7:0];
      8'h2E: return sc[15:8];
      8'h2F: return sb[15:8];
      8'h30: return sb[23:16];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_store.sv
module flash_store #(
  parameter int BYTES       = 2,
  parameter int TOTAL_BYTES = 64,
  parameter bit BIG_ENDIAN  = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [$clog2(TOTAL_BYTES)-1:0]   wr_addr,
  input  logic [8*BYTES-1:0]               wr_data,
  input  logic [$clog2(TOTAL_BYTES)-1:0]   rd_addr,
  output logic [8*BYTES-1:0]               rd_data
);
  localparam int AW = $clog2(TOTAL_BYTES);

  logic [7:0] mem [TOTAL_BYTES];

  function automatic int lane_of(input int k);
    return BIG_ENDIAN ? (BYTES - 1 - k) : k;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      for (int k = 0; k < BYTES; k++)
        mem[wr_addr + AW'(k)] <= wr_data[8*lane_of(k) +: 8];
    end
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    localparam int LANE = BIG_ENDIAN ? (BYTES - 1 - k) : k;
    logic [AW-1:0] ridx;
    assign ridx = rd_addr + AW'(k);
    assign rd_data[8*LANE +: 8] = mem[ridx];
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int BYTES        = 2,
  parameter int SECTOR_BYTES = 16,
  parameter int BUF_WORDS    = 4,
  parameter int AW           = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_protect,
  input  logic               cmd_wr,
  input  logic [AW-1:0]      addr,
  input  logic [8*BYTES-1:0] wdata,
  output logic               busy,
  output read_mode_t         rmode,
  output logic [7:0]         status,
  output logic               arr_we,
  output logic [AW-1:0]      arr_waddr,
  output logic [8*BYTES-1:0] arr_wdata,
  output logic               seq_err
);
  localparam int EWORDS = SECTOR_BYTES / BYTES;
  localparam int EW_W   = $clog2(EWORDS + 1);
  localparam int CNT_W  = $clog2(BUF_WORDS + 1);
  localparam int SEC_SH = $clog2(SECTOR_BYTES);

  seq_state_t       state;
  logic             perr;
  logic             eerr;
  logic [EW_W-1:0]  ecnt;
  logic [AW-1:0]    ebase;
  logic [CNT_W-1:0] left;
  logic [7:0]       op;
  logic [AW-1:0]    sec_base;
  logic             data_wr;
  logic             last_e;

  assign op       = wdata[7:0];
  assign sec_base = (addr >> SEC_SH) << SEC_SH;
  assign busy     = (state == ST_ERASING);
  assign data_wr  = cmd_wr && (state == ST_PROG || state == ST_BUF_DATA);
  assign last_e   = (ecnt == EW_W'(EWORDS - 1));

  assign arr_we    = busy || (data_wr && !wr_protect);
  assign arr_waddr = busy ? (ebase + AW'(ecnt * BYTES)) : addr;
  assign arr_wdata = busy ? '1 : wdata;
  assign status    = {~busy, 1'b0, eerr, perr, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rmode   <= RM_ARRAY;
      perr    <= 1'b0;
      eerr    <= 1'b0;
      ecnt    <= '0;
      ebase   <= '0;
      left    <= '0;
      seq_err <= 1'b0;
    end else begin
      seq_err <= 1'b0;
      if (busy) begin
        ecnt <= ecnt + 1'b1;
        if (last_e) begin
          state <= ST_IDLE;
          rmode <= RM_STATUS;
        end
      end else if (cmd_wr) begin
        case (state)
          ST_IDLE: begin
            case (op)
              OP_PROG_A, OP_PROG_B: begin state <= ST_PROG; rmode <= RM_STATUS; end
              OP_ERASE: begin state <= ST_ERASE_CFM; rmode <= RM_STATUS; end
              OP_CLR:   begin perr <= 1'b0; eerr <= 1'b0; rmode <= RM_STATUS; end
              OP_LOCK:  begin state <= ST_LOCK_CFM; rmode <= RM_STATUS; end
              OP_STAT:  rmode <= RM_STATUS;
              OP_IDENT: rmode <= RM_IDENT;
              OP_QUERY: rmode <= RM_QUERY;
              OP_BUFWR: begin state <= ST_BUF_CNT; rmode <= RM_STATUS; end
              OP_ARRAY: rmode <= RM_ARRAY;
              default: begin rmode <= RM_ARRAY; seq_err <= 1'b1; end
            endcase
          end
          ST_PROG: begin
            if (wr_protect) perr <= 1'b1;
            state <= ST_IDLE;
            rmode <= RM_STATUS;
          end
          ST_ERASE_CFM: begin
            if (op == OP_CONFIRM) begin
              if (wr_protect) begin
                eerr  <= 1'b1;
                state <= ST_IDLE;
                rmode <= RM_STATUS;
              end else begin
                ebase <= sec_base;
                ecnt  <= '0;
                state <= ST_ERASING;
                rmode <= RM_STATUS;
              end
            end else begin
              state <= ST_IDLE;
              rmode <= RM_ARRAY;
              if (op != OP_ARRAY) seq_err <= 1'b1;
            end
          end
          ST_LOCK_CFM: begin
            state <= ST_IDLE;
            rmode <= RM_ARRAY;
            if (op != OP_CONFIRM && op != OP_LOCK_SET) seq_err <= 1'b1;
          end
          ST_BUF_CNT: begin
            if (32'(wdata) >= BUF_WORDS) begin
              perr  <= 1'b1;
              state <= ST_IDLE;
              rmode <= RM_STATUS;
            end else begin
              left  <= CNT_W'(wdata);
              state <= ST_BUF_DATA;
            end
          end
          ST_BUF_DATA: begin
            if (wr_protect) perr <= 1'b1;
            if (left == '0) state <= ST_BUF_CFM;
            else            left  <= left - 1'b1;
          end
          ST_BUF_CFM: begin
            state <= ST_IDLE;
            if (op == OP_CONFIRM) rmode <= RM_STATUS;
            else begin
              rmode   <= RM_ARRAY;
              seq_err <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_readmux.sv
module flash_readmux
  import flash_pkg::*;
#(
  parameter int          DW           = 16,
  parameter int          ADDR_W       = 8,
  parameter int          SIZE_LOG2    = 6,
  parameter int          BUF_LOG2     = 3,
  parameter int          SECTORS      = 4,
  parameter int          SECTOR_BYTES = 16,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] DEV_CODE     = 16'h0018
) (
  input  read_mode_t        rmode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     arr_word,
  input  logic [7:0]        status,
  output logic [DW-1:0]     data
);
  logic [31:0] mfr32;
  logic [31:0] dev32;
  assign mfr32 = {16'h0000, MFR_CODE};
  assign dev32 = {16'h0000, DEV_CODE};

  always_comb begin
    data = '0;
    case (rmode)
      RM_ARRAY:  data = arr_word;
      RM_STATUS: data[7:0] = status;
      RM_IDENT: begin
        if (addr == ADDR_W'(0))      data = mfr32[DW-1:0];
        else if (addr == ADDR_W'(1)) data = dev32[DW-1:0];
      end
      RM_QUERY:  data[7:0] = qry_byte(addr[7:0], SIZE_LOG2, BUF_LOG2, SECTORS, SECTOR_BYTES);
      default:   data = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int          BYTES        = 2,
  parameter int          SECTOR_BYTES = 16,
  parameter int          SECTORS      = 4,
  parameter int          BUF_WORDS    = 4,
  parameter bit          BIG_ENDIAN   = 1'b0,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] DEV_CODE     = 16'h0018,
  localparam int         DW           = 8 * BYTES,
  localparam int         TOTAL        = SECTOR_BYTES * SECTORS,
  localparam int         AW           = $clog2(TOTAL),
  localparam int         ADDR_W       = (AW > 8) ? AW : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_protect,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              seq_error
);
  localparam int BUF_LOG2 = $clog2(BUF_WORDS * BYTES);

  logic          busy;
  logic          acc;
  read_mode_t    rmode;
  logic [7:0]    status;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] arr_word;
  logic [DW-1:0] rd_mux;

  assign req_ready = ~busy;
  assign acc       = req_valid && req_ready;

  flash_seq #(
    .BYTES(BYTES), .SECTOR_BYTES(SECTOR_BYTES), .BUF_WORDS(BUF_WORDS), .AW(AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect),
    .cmd_wr(acc && req_write), .addr(req_addr[AW-1:0]), .wdata(req_wdata),
    .busy(busy), .rmode(rmode), .status(status),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .seq_err(seq_error)
  );

  flash_store #(
    .BYTES(BYTES), .TOTAL_BYTES(TOTAL), .BIG_ENDIAN(BIG_ENDIAN)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(arr_we), .wr_addr(arr_waddr),
    .wr_data(arr_wdata), .rd_addr(req_addr[AW-1:0]), .rd_data(arr_word)
  );

  flash_readmux #(
    .DW(DW), .ADDR_W(ADDR_W), .SIZE_LOG2(AW), .BUF_LOG2(BUF_LOG2),
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_mux (
    .rmode(rmode), .addr(req_addr), .arr_word(arr_word),
    .status(status), .data(rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc && !req_write;
      if (acc && !req_write) rsp_data <= rd_mux;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [7:0] cmd_byte,
  input logic       rsp_valid,
  input logic       seq_error,
  input logic       perr,
  input logic       eerr
);
  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R2

  AST_RSP_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R14

  AST_SEQERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |-> $past(req_valid && req_ready && req_write)); // R13

  AST_STALL_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid && req_write && cmd_byte == 8'hD0)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(perr) || $fell(eerr)) |->
      $past(req_valid && req_ready && req_write && cmd_byte == 8'h50)); // R8

  AST_PERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> $past(req_valid && req_ready && req_write)); // R6

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .cmd_byte(req_wdata[7:0]), .rsp_valid(rsp_valid),
  .seq_error(seq_error), .perr(status[4]), .eerr(status[5])
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int TOT = 64;
  localparam logic [15:0] MFR = 16'h0089;
  localparam logic [15:0] DEV = 16'h0018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_protect = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        seq_error;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mem_m [TOT];

  always #2 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .seq_error(seq_error)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_word(input int a);
    return {mem_m[(a + 1) % TOT], mem_m[a % TOT]};
  endfunction

  task automatic m_store(input int a, input logic [15:0] d);
    mem_m[a % TOT] = d[7:0];
    mem_m[(a + 1) % TOT] = d[15:8];
  endtask

  task automatic bus_wr(input int a, input logic [15:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [15:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_data;
  endtask

  task automatic rd_exp(input string tag, input int a, input logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    chk(tag, {16'b0, d}, {16'b0, exp});
  endtask

  task automatic prog(input int a, input logic [15:0] d);
    bus_wr(a, 16'h0040);
    bus_wr(a, d);
    m_store(a, d);
    bus_wr(0, 16'h00FF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int stall;
    for (int i = 0; i < TOT; i++) mem_m[i] = 8'hFF;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 seq_error", {31'b0, seq_error}, 32'd0);
    chk("R14 ready idle", {31'b0, req_ready}, 32'd1);
    rd_exp("R1 erased", 0, 16'hFFFF);

    // R3 R4 program and status
    bus_wr(3, 16'h0040);
    rd_exp("R7 status after setup", 0, 16'h0080);
    bus_wr(3, 16'hA55A); m_store(3, 16'hA55A);
    rd_exp("R4 status after program", 0, 16'h0080);
    bus_wr(0, 16'h00FF);
    rd_exp("R4 readback", 3, 16'hA55A);
    rd_exp("R2 unaligned", 4, m_word(4));
    bus_wr(63, 16'h0010);
    bus_wr(63, 16'h1234); m_store(63, 16'h1234);
    bus_wr(0, 16'h00FF);
    rd_exp("R2 wrap low", 0, m_word(0));
    rd_exp("R2 wrap high", 63, 16'h1234);

    // R13 unknown command
    bus_wr(0, 16'h0033);
    chk("R13 pulse", {31'b0, seq_error}, 32'd1);
    @(negedge clk);
    chk("R13 pulse width", {31'b0, seq_error}, 32'd0);
    rd_exp("R13 array mode", 3, 16'hA55A);

    // R5 erase
    prog(16, 16'h1357); prog(30, 16'h2468); prog(14, 16'h9ABC);
    bus_wr(18, 16'h0020);
    rd_exp("R7 status in erase", 0, 16'h0080);
    bus_wr(18, 16'h00D0);
    stall = 0;
    while (!req_ready) begin stall++; @(negedge clk); end
    chk("R5 stall cycles", 32'(stall), 32'd8);
    for (int i = 16; i < 32; i++) mem_m[i] = 8'hFF;
    rd_exp("R5 status after erase", 0, 16'h0080);
    bus_wr(0, 16'h00FF);
    rd_exp("R5 erased lo", 16, 16'hFFFF);
    rd_exp("R5 erased hi", 30, 16'hFFFF);
    rd_exp("R5 neighbour kept", 14, m_word(14));

    // R5 cancel, R13 bad confirm
    prog(20, 16'hBEEF);
    bus_wr(20, 16'h0020);
    bus_wr(20, 16'h00FF);
    chk("R5 cancel no pulse", {31'b0, seq_error}, 32'd0);
    chk("R5 cancel no stall", {31'b0, req_ready}, 32'd1);
    rd_exp("R5 cancel kept", 20, 16'hBEEF);
    bus_wr(20, 16'h0020);
    bus_wr(20, 16'h0055);
    chk("R13 erase bad confirm", {31'b0, seq_error}, 32'd1);
    rd_exp("R13 erase bad kept", 20, 16'hBEEF);

    // R6 protect, R8 sticky
    prog(34, 16'h7777);
    wr_protect = 1'b1;
    bus_wr(40, 16'h0040);
    bus_wr(40, 16'h1111);
    rd_exp("R6 program error", 0, 16'h0090);
    bus_wr(0, 16'h00FF);
    rd_exp("R6 program blocked", 40, m_word(40));
    bus_wr(40, 16'h0020);
    bus_wr(40, 16'h00D0);
    chk("R6 no erase stall", {31'b0, req_ready}, 32'd1);
    rd_exp("R6 erase error", 0, 16'h00B0);
    bus_wr(0, 16'h00FF);
    rd_exp("R6 erase blocked", 34, 16'h7777);
    bus_wr(0, 16'h0070);
    rd_exp("R8 sticky", 0, 16'h00B0);
    bus_wr(0, 16'h0050);
    rd_exp("R8 cleared", 0, 16'h0080);
    wr_protect = 1'b0;

    // R9 buffered write
    bus_wr(48, 16'h00E8);
    rd_exp("R9 status after start", 0, 16'h0080);
    bus_wr(48, 16'h0002);
    bus_wr(48, 16'h1111); m_store(48, 16'h1111);
    bus_wr(50, 16'h2222); m_store(50, 16'h2222);
    bus_wr(52, 16'h3333); m_store(52, 16'h3333);
    bus_wr(48, 16'h00D0);
    chk("R9 confirm ok", {31'b0, seq_error}, 32'd0);
    rd_exp("R9 status done", 0, 16'h0080);
    bus_wr(0, 16'h00FF);
    rd_exp("R9 word0", 48, 16'h1111);
    rd_exp("R9 word1", 50, 16'h2222);
    rd_exp("R9 word2", 52, 16'h3333);
    bus_wr(0, 16'h00E8);
    bus_wr(0, 16'h0004);
    rd_exp("R9 count too big", 0, 16'h0090);
    bus_wr(0, 16'h0050);
    bus_wr(0, 16'h00FF);
    rd_exp("R9 back to idle", 48, 16'h1111);
    bus_wr(56, 16'h00E8);
    bus_wr(56, 16'h0000);
    bus_wr(56, 16'hABCD); m_store(56, 16'hABCD);
    bus_wr(56, 16'h0077);
    chk("R13 buffer bad confirm", {31'b0, seq_error}, 32'd1);
    rd_exp("R13 buffer array mode", 56, 16'hABCD);

    // R10 lock
    bus_wr(0, 16'h0060);
    rd_exp("R7 status in lock", 0, 16'h0080);
    bus_wr(0, 16'h0001);
    chk("R10 lock ok", {31'b0, seq_error}, 32'd0);
    rd_exp("R10 array after lock", 3, 16'hA55A);
    bus_wr(0, 16'h0060);
    bus_wr(0, 16'h00D0);
    chk("R10 unlock ok", {31'b0, seq_error}, 32'd0);
    rd_exp("R10 array after unlock", 3, 16'hA55A);
    bus_wr(0, 16'h0060);
    bus_wr(0, 16'h0042);
    chk("R10 bad lock value", {31'b0, seq_error}, 32'd1);

    // R11 identifier
    bus_wr(0, 16'h0090);
    rd_exp("R11 manufacturer", 0, MFR);
    rd_exp("R11 device", 1, DEV);
    rd_exp("R11 other", 2, 16'h0000);
    bus_wr(0, 16'h0070);
    rd_exp("R12 new command in ident", 0, 16'h0080);

    // R12 query
    bus_wr(0, 16'h0098);
    rd_exp("R12 Q", 8'h10, 16'h0051);
    rd_exp("R12 R", 8'h11, 16'h0052);
    rd_exp("R12 Y", 8'h12, 16'h0059);
    rd_exp("R12 size", 8'h27, 16'h0006);
    rd_exp("R12 buffer", 8'h2A, 16'h0003);
    rd_exp("R12 sectors", 8'h2D, 16'h0003);
    rd_exp("R12 past end", 8'h31, 16'h0000);
    rd_exp("R12 low index", 8'h00, 16'h0000);
    bus_wr(0, 16'h00FF);
    rd_exp("R12 leave query", 3, 16'hA55A);

    // R3 R4 R2 seeded random program/read-back
    for (int i = 0; i < 40; i++) begin
      int a;
      int ra;
      logic [15:0] d;
      a = int'($urandom % TOT);
      d = 16'($urandom);
      bus_wr(a, ($urandom % 2) ? 16'h0040 : 16'h0010);
      bus_wr(a, d); m_store(a, d);
      rd_exp("R4 random status", 0, 16'h0080);
      bus_wr(0, 16'h00FF);
      rd_exp("R4 random same addr", a, m_word(a));
      ra = int'($urandom % TOT);
      rd_exp("R2 random addr", ra, m_word(ra));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule